// File: doc/BRIEF.md
# Carry-Select Dynamic Add/Subtract Slice

A slice of a run-time configurable adder of parameterized width. The default width is 10 bits. One control input picks the operation. When it is low the slice adds its two operands and its carry input. When it is high the slice forms A minus B: it inverts every bit of B and injects a carry of one.

Each bit position works out its result twice, once as if the incoming carry were zero and once as if it were one. This gives two full carry chains that settle independently of the slice carry input. The effective carry entering the slice then picks one chain late: the sums, the carry out of the top bit and the carry into it. The selected sum is captured in a result register that has a synchronous clear and a synchronous load. Clear wins when both are high.

Carry-out and the signed-overflow flag are combinational from the present inputs. A wider adder is built by wiring one slice's carry-out to the next slice's carry input, in add mode.

Top module: `csel_addsub_slice`

## Requirements
- R1: After the asynchronous reset (rst_n low) the registered result sum_q is 0.
- R2: With add_sub_n = 0, load = 1 and clr = 0, the next rising edge captures (op_a + op_b + carry_in) mod 2^W into sum_q.
- R3: With add_sub_n = 1, load = 1 and clr = 0, the next rising edge captures (op_a - op_b) mod 2^W into sum_q, whatever the value of carry_in.
- R4: carry_out is combinational. In add mode it is bit W of op_a + op_b + carry_in. In subtract mode it is 1 exactly when op_a >= op_b as unsigned numbers.
- R5: overflow is combinational. It is 1 exactly when the two's-complement result of the selected operation falls outside [-2^(W-1), 2^(W-1)-1]. In add mode carry_in is counted as +1.
- R6: clr = 1 sets sum_q to 0 at the next rising edge, even when load = 1.
- R7: With clr = 0 and load = 0, sum_q keeps its value across an edge while the operands and mode change.
- R8: Two slices chained in add mode, carry_out of the low slice to carry_in of the high one, form a 2W-bit sum {high sum_q, low sum_q} equal to (A + B + low carry_in) mod 2^(2W).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | First operand |
| op_b | input | W | Second operand, inverted in subtract mode |
| add_sub_n | input | 1 | 0 = add, 1 = subtract |
| carry_in | input | 1 | Slice carry input, used in add mode |
| clr | input | 1 | Synchronous clear of sum_q, takes priority |
| load | input | 1 | Synchronous capture of the selected sum |
| sum_q | output | W | Registered result |
| carry_out | output | 1 | Carry out of the selected chain |
| overflow | output | 1 | Signed overflow of the selected result |

## Verification
The clocked properties assume that operands, mode and control inputs are stable at the rising edge and are known after reset. The bench meets this by changing every input only on falling edges. The overflow and borrow properties judge the selected sum by operand signs and by unsigned magnitude. This assumes that carry_in is ignored in subtract mode, so the bench drives carry_in high during subtract cases to test that assumption. The chain-ordering check inside each cell assumes the one-carry chain is never lower than the zero-carry chain at that cell's input. The forced 0 and 1 at the chain roots guarantee this.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // generate/propagate of one bit pair: {g, p}
  function automatic logic [1:0] gen_prop(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

  function automatic logic carry_next(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

  // signed overflow from the carries around the top bit
  function automatic logic signed_ovf(input logic c_into_top, input logic c_out_top);
    return c_into_top ^ c_out_top;
  endfunction
endpackage

// File: rtl/csel_bit_cell.sv
module csel_bit_cell
  import csel_pkg::*;
(
  input  logic a,
  input  logic b_eff,
  input  logic c0_in,
  input  logic c1_in,
  output logic s0,
  output logic s1,
  output logic c0_out,
  output logic c1_out
);
  logic [1:0] gp;

  always_comb begin
    gp     = gen_prop(a, b_eff);
    s0     = gp[0] ^ c0_in;
    s1     = gp[0] ^ c1_in;
    c0_out = carry_next(gp[1], gp[0], c0_in);
    c1_out = carry_next(gp[1], gp[0], c1_in);
  end

  // R4: chain ordering is preserved: if the zero-assumed chain carries, so does the one-assumed chain
  always_comb begin
    if (!(c0_in && !c1_in))
      assert_chain_order_R4: assert (!(c0_out && !c1_out));
  end
endmodule

// File: rtl/csel_dual_chain.sv
module csel_dual_chain #(
  parameter int W = 10
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  output logic [W-1:0] sum0,
  output logic [W-1:0] sum1,
  output logic [W:0]   chain0,
  output logic [W:0]   chain1
);
  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_cell
    csel_bit_cell u_cell (
      .a      (a[i]),
      .b_eff  (b_eff[i]),
      .c0_in  (chain0[i]),
      .c1_in  (chain1[i]),
      .s0     (sum0[i]),
      .s1     (sum1[i]),
      .c0_out (chain0[i+1]),
      .c1_out (chain1[i+1])
    );
  end
endmodule

// File: rtl/csel_late_select.sv
module csel_late_select #(
  parameter int W = 10
) (
  input  logic [W-1:0] sum0,
  input  logic [W-1:0] sum1,
  input  logic [W:0]   chain0,
  input  logic [W:0]   chain1,
  input  logic         cin_eff,
  output logic [W-1:0] sum_sel,
  output logic         carry_out,
  output logic         carry_top_in
);
  always_comb begin
    sum_sel      = cin_eff ? sum1 : sum0;
    carry_out    = cin_eff ? chain1[W] : chain0[W];
    carry_top_in = cin_eff ? chain1[W-1] : chain0[W-1];
  end
endmodule

// File: rtl/csel_result_reg.sv
module csel_result_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (load)  q <= d;
  end

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (q == $past(d)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(q));
endmodule

// File: rtl/csel_addsub_slice.sv
module csel_addsub_slice
  import csel_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         add_sub_n,
  input  logic         carry_in,
  input  logic         clr,
  input  logic         load,
  output logic [W-1:0] sum_q,
  output logic         carry_out,
  output logic         overflow
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W-1:0] sum0, sum1, sum_sel;
  logic [W:0]   chain0, chain1;
  logic         cin_eff;
  logic         carry_top_in;

  assign b_eff   = op_b ^ {W{add_sub_n}};
  assign cin_eff = add_sub_n | carry_in;

  csel_dual_chain #(.W(W)) u_chain (
    .a      (op_a),
    .b_eff  (b_eff),
    .sum0   (sum0),
    .sum1   (sum1),
    .chain0 (chain0),
    .chain1 (chain1)
  );

  csel_late_select #(.W(W)) u_sel (
    .sum0         (sum0),
    .sum1         (sum1),
    .chain0       (chain0),
    .chain1       (chain1),
    .cin_eff      (cin_eff),
    .sum_sel      (sum_sel),
    .carry_out    (carry_out),
    .carry_top_in (carry_top_in)
  );

  assign overflow = signed_ovf(carry_top_in, carry_out);

  csel_result_reg #(.W(W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .load  (load),
    .d     (sum_sel),
    .q     (sum_q)
  );

  // R5: overflow judged by operand and result signs
  assert_ovf_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !add_sub_n |-> (overflow == ((op_a[MSB] == op_b[MSB]) && (sum_sel[MSB] != op_a[MSB]))));

  assert_ovf_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    add_sub_n |-> (overflow == ((op_a[MSB] != op_b[MSB]) && (sum_sel[MSB] != op_a[MSB]))));

  // R4: in subtract mode the carry out means "no borrow"
  assert_no_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    add_sub_n |-> (carry_out == (op_a >= op_b)));

  // R3: subtraction result is independent of the slice carry input
  assert_sub_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    add_sub_n |-> (sum_sel == W'(op_a - op_b)));
endmodule

// File: tb/csel_addsub_slice_tb_top.sv
module csel_addsub_slice_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, hi_a = '0, hi_b = '0;
  logic         add_sub_n = 1'b0, carry_in = 1'b0, clr = 1'b0, load = 1'b0;
  logic         hi_load = 1'b0;
  logic [W-1:0] sum_q, hi_sum;
  logic         carry_out, overflow, hi_cout, hi_ovf;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  csel_addsub_slice #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .add_sub_n(add_sub_n),
    .carry_in(carry_in), .clr(clr), .load(load),
    .sum_q(sum_q), .carry_out(carry_out), .overflow(overflow)
  );

  csel_addsub_slice #(.W(W)) dut_hi (
    .clk(clk), .rst_n(rst_n), .op_a(hi_a), .op_b(hi_b), .add_sub_n(1'b0),
    .carry_in(carry_out), .clr(1'b0), .load(hi_load),
    .sum_q(hi_sum), .carry_out(hi_cout), .overflow(hi_ovf)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= (1 << (W-1))) ? v - (1 << W) : v;
  endfunction

  // one operation: combinational checks before the edge, register check after it
  task automatic run_op(input int a, input int b, input bit sub, input bit cin);
    int full, exp_sum, exp_c, sres;
    bit exp_o;
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); add_sub_n = sub; carry_in = cin; load = 1'b1; clr = 1'b0;
    if (sub) begin
      exp_sum = (a - b) & ((1 << W) - 1);
      exp_c   = (a >= b) ? 1 : 0;
      sres    = to_signed(a) - to_signed(b);
    end else begin
      full    = a + b + int'(cin);
      exp_sum = full & ((1 << W) - 1);
      exp_c   = full >> W;
      sres    = to_signed(a) + to_signed(b) + int'(cin);
    end
    exp_o = (sres > (1 << (W-1)) - 1) || (sres < -(1 << (W-1)));
    #1;
    check("R4 carry_out", carry_out, exp_c);
    check("R5 overflow", overflow, exp_o);
    @(negedge clk);
    load = 1'b0;
    check(sub ? "R3 subtract" : "R2 add", sum_q, exp_sum);
  endtask

  task automatic t_reset;
    check("R1 reset value", sum_q, 0);
  endtask

  task automatic t_clear_priority;
    run_op(300, 5, 1'b0, 1'b0);
    @(negedge clk);
    op_a = 10; op_b = 20; clr = 1'b1; load = 1'b1;
    @(negedge clk);
    clr = 1'b0; load = 1'b0;
    check("R6 clear over load", sum_q, 0);
  endtask

  task automatic t_hold;
    run_op(123, 77, 1'b0, 1'b0);
    @(negedge clk);
    op_a = 999; op_b = 1; add_sub_n = 1'b1; load = 1'b0; clr = 1'b0;
    @(negedge clk);
    check("R7 hold", sum_q, 200);
    @(negedge clk);
    op_a = 0; op_b = 1000; add_sub_n = 1'b0;
    @(negedge clk);
    check("R7 hold", sum_q, 200);
  endtask

  task automatic t_chain(input int a20, input int b20, input bit cin);
    int exp20;
    @(negedge clk);
    op_a = W'(a20); op_b = W'(b20); hi_a = W'(a20 >> W); hi_b = W'(b20 >> W);
    add_sub_n = 1'b0; carry_in = cin; clr = 1'b0; load = 1'b1; hi_load = 1'b1;
    exp20 = (a20 + b20 + int'(cin)) & ((1 << (2*W)) - 1);
    @(negedge clk);
    load = 1'b0; hi_load = 1'b0;
    check("R8 chained sum", {hi_sum, sum_q}, exp20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op(100, 200, 1'b0, 1'b0);
    run_op(100, 200, 1'b0, 1'b1);
    run_op(1023, 1, 1'b0, 1'b0);
    run_op(1023, 0, 1'b0, 1'b1);
    run_op(511, 1, 1'b0, 1'b0);
    run_op(512, 512, 1'b0, 1'b0);
    run_op(511, 0, 1'b0, 1'b1);
    run_op(300, 100, 1'b1, 1'b1);
    run_op(100, 300, 1'b1, 1'b0);
    run_op(5, 5, 1'b1, 1'b1);
    run_op(512, 1, 1'b1, 1'b0);
    run_op(511, 1023, 1'b1, 1'b1);
    run_op(0, 0, 1'b1, 1'b0);
    t_clear_priority();
    t_hold();
    t_chain(20'h003FF, 20'h00001, 1'b0);
    t_chain(20'h12345, 20'h0ABCD, 1'b1);
    t_chain(20'hFFFFF, 20'h00000, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule